// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block adds an addend register into an accumulator register one bit per clock. It uses a single full adder and one carry flip-flop. A pulse on the start input launches an add of exactly WIDTH shift cycles. In each of those cycles the following happens:

- The low bits of both registers and the stored carry enter the full adder.
- The sum bit is shifted into the top of the accumulator.
- The addend rotates right.
- The carry-out is kept for the next bit.

When the add completes, the accumulator holds the sum modulo 2^WIDTH, the carry output holds the bit that fell off the top, and the addend is back to its starting value.

Both registers can be loaded in parallel while no add is running. Holding start high chains adds back to back, so the addend is accumulated again each WIDTH cycles. The carry is forced to zero for the first bit of every add, so a carry left from an earlier add never reaches bit 0.

Top module: `serial_acc_adder`

## Requirements
- R1: A synchronous reset clears the carry flip-flop and returns the controller to idle. After reset, with start low and no load, the accumulator and addend do not change.
- R2: During an add both registers shift right once per cycle, and the accumulator's MSB receives the full-adder sum. After WIDTH shifts the accumulator equals (A + B) mod 2^WIDTH, where A is its starting value and B is the addend.
- R3: The addend's MSB receives its own bit 0, so it rotates right each shift and equals its starting value after WIDTH shifts. For 0111 the successive values are 1011, 1101, 1110 and 0111.
- R4: Start sampled high while idle launches an add of exactly WIDTH shift cycles. The level of start during those cycles has no effect on their number.
- R5: While idle with start low and no load, the accumulator, the addend and the carry hold their values.
- R6: After an add, carryOut equals bit WIDTH of A + B. The first bit of the next add uses a carry-in of 0 whatever carryOut held.
- R7: loadAcc and loadAddend copy accIn and addendIn into their registers on the next edge when no shift occurs. A load requested during a shift cycle is ignored.
- R8: With start held high, a new add begins on the cycle right after the previous add's last shift. Each such add adds the addend into the running sum again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launches an add when sampled high while idle |
| loadAcc | input | 1 | Parallel load of the accumulator |
| accIn | input | WIDTH | Accumulator load value |
| loadAddend | input | 1 | Parallel load of the addend |
| addendIn | input | WIDTH | Addend load value |
| accOut | output | WIDTH | Accumulator contents |
| addendOut | output | WIDTH | Addend contents |
| carryOut | output | 1 | Stored carry flip-flop |

## Verification
The hardest situation to reach is a stale carry meeting the first bit of a new add. The carry flip-flop is visible only after a full add, and a fresh add must start from it at once. The stimulus first adds 1111 and 0001 to leave a carry of 1. It then loads zeros and starts a second add, so any leak of the old carry shows up as 0001 instead of 0000. Loads issued mid-add and start held across a chained pair of adds cover the remaining timing-dependent paths.

// File: rtl/serial_acc_pkg.sv
package serial_acc_pkg;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic shiftEn;   // shift both registers and capture carry this cycle
    logic firstBit;  // this shift handles bit 0: carry-in forced to zero
  } sa_strobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sa_state_e;

endpackage

// File: rtl/sa_control.sv
module sa_control
  import serial_acc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output sa_strobe_t strobes
);

  localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WIDTH - 1);

  sa_state_e       state, stateNext;
  logic [CNT_W-1:0] bitCnt, bitCntNext;

  always_comb begin
    stateNext        = state;
    bitCntNext       = bitCnt;
    strobes.shiftEn  = 1'b0;
    strobes.firstBit = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobes.shiftEn  = 1'b1;
          strobes.firstBit = 1'b1;
          stateNext        = ST_RUN;
          bitCntNext       = CNT_W'(1);
        end
      end
      ST_RUN: begin
        strobes.shiftEn = 1'b1;
        if (bitCnt == LAST_BIT) begin
          stateNext  = ST_IDLE;
          bitCntNext = '0;
        end else begin
          bitCntNext = bitCnt + CNT_W'(1);
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= stateNext;
      bitCnt <= bitCntNext;
    end
  end

endmodule

// File: rtl/sa_full_adder.sv
module sa_full_adder (
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic sum,
  output logic cout
);

  always_comb begin
    sum  = a ^ b ^ cin;
    cout = (a & b) | (a & cin) | (b & cin);
  end

endmodule

// File: rtl/sa_datapath.sv
module sa_datapath
  import serial_acc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  sa_strobe_t       strobes,
  input  logic             loadAcc,
  input  logic [WIDTH-1:0] accIn,
  input  logic             loadAddend,
  input  logic [WIDTH-1:0] addendIn,
  output logic [WIDTH-1:0] accQ,
  output logic [WIDTH-1:0] addendQ,
  output logic             carryQ
);

  logic carryIn, sumBit, carryNext;

  // A fresh add never sees the carry left by the previous one
  assign carryIn = strobes.firstBit ? 1'b0 : carryQ;

  sa_full_adder i_fa (
    .a   (accQ[0]),
    .b   (addendQ[0]),
    .cin (carryIn),
    .sum (sumBit),
    .cout(carryNext)
  );

  always_ff @(posedge clk) begin
    if (strobes.shiftEn) begin
      accQ    <= {sumBit, accQ[WIDTH-1:1]};
      addendQ <= {addendQ[0], addendQ[WIDTH-1:1]};
    end else begin
      if (loadAcc)    accQ    <= accIn;
      if (loadAddend) addendQ <= addendIn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  carryQ <= 1'b0;
    else if (strobes.shiftEn) carryQ <= carryNext;
  end

endmodule

// File: rtl/serial_acc_adder.sv
module serial_acc_adder
  import serial_acc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             loadAcc,
  input  logic [WIDTH-1:0] accIn,
  input  logic             loadAddend,
  input  logic [WIDTH-1:0] addendIn,
  output logic [WIDTH-1:0] accOut,
  output logic [WIDTH-1:0] addendOut,
  output logic             carryOut
);

  sa_strobe_t strobes;

  sa_control #(.WIDTH(WIDTH)) i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .strobes(strobes)
  );

  sa_datapath #(.WIDTH(WIDTH)) i_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .loadAcc   (loadAcc),
    .accIn     (accIn),
    .loadAddend(loadAddend),
    .addendIn  (addendIn),
    .accQ      (accOut),
    .addendQ   (addendOut),
    .carryQ    (carryOut)
  );

endmodule

// File: rtl/sa_checker.sv
module sa_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             loadAcc,
  input logic [WIDTH-1:0] accOut,
  input logic [WIDTH-1:0] addendOut,
  input logic             carryOut,
  input logic             shiftNow
);

  localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WIDTH - 1);

  // Position inside the current add, counted independently of the controller
  logic [CNT_W-1:0] shiftCnt;
  always_ff @(posedge clk) begin
    if (rst)           shiftCnt <= '0;
    else if (shiftNow) shiftCnt <= (shiftCnt == LAST_BIT) ? '0 : shiftCnt + CNT_W'(1);
  end

  p_reset_carry_r1: assert property (@(posedge clk) $past(rst) |-> !carryOut);

  p_acc_shift_r2: assert property (@(posedge clk) disable iff (rst)
    shiftNow |=> accOut[WIDTH-2:0] == $past(accOut[WIDTH-1:1]));

  p_addend_rotate_r3: assert property (@(posedge clk) disable iff (rst)
    shiftNow |=> addendOut == {$past(addendOut[0]), $past(addendOut[WIDTH-1:1])});

  p_full_run_r4: assert property (@(posedge clk) disable iff (rst)
    (shiftCnt != '0) |-> shiftNow);

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!shiftNow && !loadAcc) |=> $stable(accOut));

  p_carry_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !shiftNow |=> $stable(carryOut));

endmodule

bind serial_acc_adder sa_checker #(.WIDTH(WIDTH)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .loadAcc  (loadAcc),
  .accOut   (accOut),
  .addendOut(addendOut),
  .carryOut (carryOut),
  .shiftNow (strobes.shiftEn)
);

// File: tb/test_serial_acc_adder.sv
module test_serial_acc_adder;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic         loadAcc;
  logic [W-1:0] accIn;
  logic         loadAddend;
  logic [W-1:0] addendIn;
  logic [W-1:0] accOut;
  logic [W-1:0] addendOut;
  logic         carryOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  serial_acc_adder #(.WIDTH(W)) i_serial_acc_adder (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .loadAcc   (loadAcc),
    .accIn     (accIn),
    .loadAddend(loadAddend),
    .addendIn  (addendIn),
    .accOut    (accOut),
    .addendOut (addendOut),
    .carryOut  (carryOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic loadBoth(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    loadAcc = 1'b1; accIn = a; loadAddend = 1'b1; addendIn = b;
    @(negedge clk);
    loadAcc = 1'b0; loadAddend = 1'b0;
  endtask

  // One start pulse, then wait for the W shift edges; returns at a negedge
  task automatic runAdd();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (W - 1) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 carry after reset", 8'(carryOut), 8'd0);
    loadBoth(4'h9, 4'h6);
    repeat (3) @(negedge clk);
    check("R1 acc idle after reset", 8'(accOut), 8'h9);
    check("R7 addend loaded", 8'(addendOut), 8'h6);
  endtask

  task automatic testExample();
    loadBoth(4'b0101, 4'b0111);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R3 addend step 1", 8'(addendOut), 8'b1011);
    @(negedge clk);
    check("R3 addend step 2", 8'(addendOut), 8'b1101);
    @(negedge clk);
    check("R3 addend step 3", 8'(addendOut), 8'b1110);
    @(negedge clk);
    check("R2 example sum", 8'(accOut), 8'b1100);
    check("R3 addend restored", 8'(addendOut), 8'b0111);
    check("R6 example carry", 8'(carryOut), 8'd0);
  endtask

  task automatic testRandom();
    for (int i = 0; i < 24; i++) begin
      logic [W-1:0] a, b;
      logic [W:0]   s;
      a = W'($urandom);
      b = W'($urandom);
      s = {1'b0, a} + {1'b0, b};
      loadBoth(a, b);
      runAdd();
      check("R2 random sum", 8'(accOut), 8'(s[W-1:0]));
      check("R6 random carry", 8'(carryOut), 8'(s[W]));
      check("R3 random addend", 8'(addendOut), 8'(b));
    end
  endtask

  task automatic testStaleCarry();
    loadBoth(4'hF, 4'h1);
    runAdd();
    check("R6 overflow carry", 8'(carryOut), 8'd1);
    check("R6 overflow sum", 8'(accOut), 8'h0);
    loadBoth(4'h0, 4'h0);
    runAdd();
    check("R6 stale carry not used", 8'(accOut), 8'h0);
    check("R6 carry cleared", 8'(carryOut), 8'd0);
  endtask

  task automatic testHold();
    loadBoth(4'hA, 4'h3);
    repeat (6) @(negedge clk);
    check("R5 acc held", 8'(accOut), 8'hA);
    check("R5 addend held", 8'(addendOut), 8'h3);
  endtask

  task automatic testStartMidAdd();
    // start raised again mid-add must not lengthen it (R4)
    loadBoth(4'h2, 4'h5);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check("R4 sum after W shifts", 8'(accOut), 8'h7);
    repeat (3) @(negedge clk);
    check("R4 no extra shifts", 8'(accOut), 8'h7);
    check("R4 addend at rest", 8'(addendOut), 8'h5);
  endtask

  task automatic testLoadDuringAdd();
    loadBoth(4'h4, 4'h6);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    loadAcc = 1'b1; accIn = 4'hF; loadAddend = 1'b1; addendIn = 4'hF;
    @(negedge clk);
    loadAcc = 1'b0; loadAddend = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 load ignored in add, sum", 8'(accOut), 8'hA);
    check("R7 load ignored in add, addend", 8'(addendOut), 8'h6);
  endtask

  task automatic testBackToBack();
    loadBoth(4'h3, 4'h5);
    @(negedge clk);
    start = 1'b1;
    repeat (W) @(negedge clk);
    check("R8 first chained sum", 8'(accOut), 8'h8);
    @(negedge clk);
    start = 1'b0;
    repeat (W - 1) @(negedge clk);
    check("R8 second chained sum", 8'(accOut), 8'hD);
    check("R8 chained carry", 8'(carryOut), 8'd0);
    repeat (2) @(negedge clk);
    check("R8 stops after start drops", 8'(accOut), 8'hD);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; loadAcc = 1'b0; loadAddend = 1'b0;
    accIn = '0; addendIn = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    testReset();
    testExample();
    testRandom();
    testStaleCarry();
    testHold();
    testStartMidAdd();
    testLoadDuringAdd();
    testBackToBack();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule